// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge and Vector Unit

This block joins two eight-line priority resolvers, an upper one and a lower one, into a single sixteen-line interrupt source. The lower resolver's request output feeds input line 2 of the upper resolver through a one-cycle register. The system interrupt output is the upper resolver's request. Each resolver scans its unmasked request lines with line 0 as the highest priority. It reports a winner only when that winner outranks every line it has in service.

A one-cycle acknowledge strobe from the processor starts a vector fetch. On the next clock the block presents an eight-bit vector with a valid flag. The vector is built from the base of the resolver that owns the winning line, with the base's three low bits replaced by the line number. A winner on the cascade line starts a second-level acknowledge of the lower resolver. When a resolver has nothing to offer at acknowledge time, line 7 is substituted. Each resolver has a non-specific end-of-interrupt strobe that retires its highest-priority in-service line. The in-service sets are brought out as ports.

Top module: `casc_irq_ack`

## Requirements
- R1: Bit 2 of `up_req` is ignored. Upper line 2 is driven instead by the lower resolver's request, registered once. `sys_irq` follows the upper resolver's request in the same cycle as its inputs and state.
- R2: If `ack` is high and the upper winner is a line other than 2, `vector` is upper base[7:3] followed by the line number on bits [2:0], and that line's bit is set in `up_isr`.
- R3: If `ack` is high, the upper winner is line 2 and the lower resolver has a winner, `vector` is lower base[7:3] followed by the lower line number. Bit 2 of `up_isr` is set, and the lower line's bit is set in `lo_isr`.
- R4: If `ack` is high, the upper winner is line 2 and the lower resolver has no winner, `vector` is lower base[7:3] followed by 7. Bit 2 of `up_isr` is set and `lo_isr` is unchanged.
- R5: If `ack` is high and the upper resolver has no winner, `vector` is upper base[7:3] followed by 7, and neither in-service set changes.
- R6: Bits [2:0] of `up_base` and `lo_base` never affect `vector`.
- R7: `vec_valid` is high exactly in the cycle after a cycle with `ack` high. `vector` holds its value when there is no acknowledge. After reset both are zero.
- R8: A pending line whose priority is equal to or lower than the highest-priority in-service line of its resolver does not produce a winner. Line 0 has the highest priority.
- R9: An end-of-interrupt strobe (`up_eoi`, `lo_eoi`) clears the lowest-numbered set bit of that resolver's in-service set. It has no effect when the set is empty.
- R10: A request line whose mask bit (`up_mask`, `lo_mask`) is 1 never wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 8 | Upper resolver request levels (bit 2 unused) |
| lo_req | input | 8 | Lower resolver request levels (system lines 8 to 15) |
| up_mask | input | 8 | Upper line masks, 1 blocks the line |
| lo_mask | input | 8 | Lower line masks, 1 blocks the line |
| up_base | input | 8 | Upper vector base, bits [7:3] used |
| lo_base | input | 8 | Lower vector base, bits [7:3] used |
| ack | input | 1 | One-cycle acknowledge strobe |
| up_eoi | input | 1 | Upper end-of-interrupt strobe |
| lo_eoi | input | 1 | Lower end-of-interrupt strobe |
| sys_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| vector | output | 8 | Interrupt vector |
| up_isr | output | 8 | Upper in-service set |
| lo_isr | output | 8 | Lower in-service set |

## Verification
Several properties are checked on every cycle. The valid flag follows each strobe and no other cycle. An upper spurious acknowledge leaves the in-service set alone and yields the line-7 vector on the upper base. Each real upper acknowledge adds exactly one in-service bit. An end-of-interrupt removes exactly one. A raised interrupt never comes from a line at or below the in-service level. Some cases can only be reached by the bench's scenarios and its per-cycle reference model. These are the two-level acknowledge with its slave bit, the lower spurious case after the lower request drops behind the cascade register, the ignored upper line 2, masking, and the unused base bits.

// File: rtl/casc_irq_ack_pkg.sv
package casc_irq_ack_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE      = 3'd0,
    KIND_UPPER     = 3'd1,
    KIND_CASCADE   = 3'd2,
    KIND_CASC_SPUR = 3'd3,
    KIND_UP_SPUR   = 3'd4
  } ack_kind_e;

  // index of the lowest set bit, 32 when none is set
  function automatic int first_set(input logic [31:0] v);
    int r;
    r = 32;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

  // vector = base with its low bits replaced by the line number
  function automatic logic [7:0] fold_vector(input logic [7:0] base,
                                             input logic [7:0] line,
                                             input int lw);
    logic [7:0] keep;
    keep = 8'hFF << lw;
    return (base & keep) | (line & ~keep);
  endfunction

endpackage

// File: rtl/prio_resolver.sv
module prio_resolver
  import casc_irq_ack_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LINES-1:0]          req,
  input  logic [LINES-1:0]          mask,
  input  logic                      ack_set,
  input  logic [$clog2(LINES)-1:0]  ack_line,
  input  logic                      eoi,
  output logic                      hit,
  output logic [$clog2(LINES)-1:0]  win_line,
  output logic [LINES-1:0]          isr
);
  localparam int LW = $clog2(LINES);

  logic [LINES-1:0] pend;
  logic [LINES-1:0] clr_bits;
  logic [LINES-1:0] set_bits;
  logic [LINES-1:0] isr_next;
  int               pend_idx;
  int               serv_idx;

  assign pend     = req & ~mask;
  assign pend_idx = first_set(32'(pend));
  assign serv_idx = first_set(32'(isr));
  assign hit      = (pend_idx < serv_idx);
  assign win_line = LW'(pend_idx);

  always_comb begin
    clr_bits = '0;
    set_bits = '0;
    for (int k = 0; k < LINES; k++) begin
      clr_bits[k] = eoi && (serv_idx == k);
      set_bits[k] = ack_set && (ack_line == LW'(k));
    end
    isr_next = (isr & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_next;
  end
endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer
  import casc_irq_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack,
  input  logic                      up_hit,
  input  logic [$clog2(LINES)-1:0]  up_line,
  input  logic                      lo_hit,
  input  logic [$clog2(LINES)-1:0]  lo_line,
  input  logic [VEC_W-1:0]          up_base,
  input  logic [VEC_W-1:0]          lo_base,
  output logic                      up_ack,
  output logic                      lo_ack,
  output ack_kind_e                 kind,
  output logic                      vec_valid,
  output logic [VEC_W-1:0]          vector
);
  localparam int LW = $clog2(LINES);
  localparam logic [LW-1:0] SPUR = LW'(LINES - 1);

  logic [VEC_W-1:0] vec_d;

  always_comb begin
    if (!ack)                            kind = KIND_IDLE;
    else if (!up_hit)                    kind = KIND_UP_SPUR;
    else if (up_line != LW'(CASC_LINE))  kind = KIND_UPPER;
    else if (lo_hit)                     kind = KIND_CASCADE;
    else                                 kind = KIND_CASC_SPUR;
  end

  assign up_ack = (kind == KIND_UPPER) || (kind == KIND_CASCADE) ||
                  (kind == KIND_CASC_SPUR);
  assign lo_ack = (kind == KIND_CASCADE);

  always_comb begin
    case (kind)
      KIND_UPPER:     vec_d = VEC_W'(fold_vector(8'(up_base), 8'(up_line), LW));
      KIND_CASCADE:   vec_d = VEC_W'(fold_vector(8'(lo_base), 8'(lo_line), LW));
      KIND_CASC_SPUR: vec_d = VEC_W'(fold_vector(8'(lo_base), 8'(SPUR), LW));
      KIND_UP_SPUR:   vec_d = VEC_W'(fold_vector(8'(up_base), 8'(SPUR), LW));
      default:        vec_d = vector;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vector    <= '0;
    end else begin
      vec_valid <= ack;
      vector    <= vec_d;
    end
  end
endmodule

// File: rtl/casc_irq_ack.sv
module casc_irq_ack
  import casc_irq_ack_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] up_req,
  input  logic [LINES-1:0] lo_req,
  input  logic [LINES-1:0] up_mask,
  input  logic [LINES-1:0] lo_mask,
  input  logic [VEC_W-1:0] up_base,
  input  logic [VEC_W-1:0] lo_base,
  input  logic             ack,
  input  logic             up_eoi,
  input  logic             lo_eoi,
  output logic             sys_irq,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vector,
  output logic [LINES-1:0] up_isr,
  output logic [LINES-1:0] lo_isr
);
  localparam int LW = $clog2(LINES);

  logic             casc_q;
  logic [LINES-1:0] up_req_eff;
  logic             up_hit;
  logic             lo_hit;
  logic [LW-1:0]    up_line;
  logic [LW-1:0]    lo_line;
  logic             up_ack;
  logic             lo_ack;
  ack_kind_e        kind;

  // upper line CASC_LINE is owned by the registered lower request
  always_comb begin
    for (int k = 0; k < LINES; k++) begin
      up_req_eff[k] = (k == CASC_LINE) ? casc_q : up_req[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= lo_hit;
  end

  prio_resolver #(.LINES(LINES)) u_upper (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (up_req_eff),
    .mask     (up_mask),
    .ack_set  (up_ack),
    .ack_line (up_line),
    .eoi      (up_eoi),
    .hit      (up_hit),
    .win_line (up_line),
    .isr      (up_isr)
  );

  prio_resolver #(.LINES(LINES)) u_lower (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (lo_req),
    .mask     (lo_mask),
    .ack_set  (lo_ack),
    .ack_line (lo_line),
    .eoi      (lo_eoi),
    .hit      (lo_hit),
    .win_line (lo_line),
    .isr      (lo_isr)
  );

  ack_sequencer #(
    .LINES     (LINES),
    .VEC_W     (VEC_W),
    .CASC_LINE (CASC_LINE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .up_hit    (up_hit),
    .up_line   (up_line),
    .lo_hit    (lo_hit),
    .lo_line   (lo_line),
    .up_base   (up_base),
    .lo_base   (lo_base),
    .up_ack    (up_ack),
    .lo_ack    (lo_ack),
    .kind      (kind),
    .vec_valid (vec_valid),
    .vector    (vector)
  );

  assign sys_irq = up_hit;
endmodule

// File: rtl/casc_irq_ack_checker.sv
module casc_irq_ack_checker #(
  parameter int LINES = 8,
  parameter int VEC_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ack,
  input logic                     up_eoi,
  input logic                     sys_irq,
  input logic [VEC_W-1:0]         up_base,
  input logic                     vec_valid,
  input logic [VEC_W-1:0]         vector,
  input logic [LINES-1:0]         up_isr,
  input logic [$clog2(LINES)-1:0] up_line
);
  localparam int LW = $clog2(LINES);

  function automatic logic [LINES-1:0] upto(input logic [LW-1:0] line);
    logic [LINES-1:0] m;
    for (int k = 0; k < LINES; k++) m[k] = (k <= int'(line));
    return m;
  endfunction

  assert_valid_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  assert_upper_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !sys_irq && !up_eoi) |=>
      (vector[LW-1:0] == LW'(LINES - 1)) &&
      (vector[VEC_W-1:LW] == $past(up_base[VEC_W-1:LW])) &&
      (up_isr == $past(up_isr)));

  assert_ack_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && sys_irq && !up_eoi) |=>
      ($countones(up_isr) == $countones($past(up_isr)) + 1));

  assert_eoi_removes_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_eoi && !ack && (up_isr != '0)) |=>
      ($countones(up_isr) + 1 == $countones($past(up_isr))));

  assert_win_above_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq |-> ((up_isr & upto(up_line)) == '0));
endmodule

bind casc_irq_ack casc_irq_ack_checker #(.LINES(LINES), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .up_eoi    (up_eoi),
  .sys_irq   (sys_irq),
  .up_base   (up_base),
  .vec_valid (vec_valid),
  .vector    (vector),
  .up_isr    (up_isr),
  .up_line   (up_line)
);

// File: tb/casc_irq_ack_test.sv
`timescale 1ns/1ps
module casc_irq_ack_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] up_req = '0, lo_req = '0, up_mask = '0, lo_mask = '0;
  logic [7:0] up_base = 8'h25, lo_base = 8'h73;
  logic       ack = 1'b0, up_eoi = 1'b0, lo_eoi = 1'b0;
  logic       sys_irq, vec_valid;
  logic [7:0] vector, up_isr, lo_isr;

  int checks = 0;
  int fails  = 0;

  // reference state
  int         m_isr[8];
  int         s_isr[8];
  int         m_casc = 0;
  int         m_vld  = 0;
  int         m_vec  = 0;

  always #5 clk = ~clk;

  casc_irq_ack uut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .lo_req(lo_req),
    .up_mask(up_mask), .lo_mask(lo_mask), .up_base(up_base), .lo_base(lo_base),
    .ack(ack), .up_eoi(up_eoi), .lo_eoi(lo_eoi), .sys_irq(sys_irq),
    .vec_valid(vec_valid), .vector(vector), .up_isr(up_isr), .lo_isr(lo_isr)
  );

  // scan from top priority; an in-service line stops the scan
  function automatic int pick(input logic [7:0] rq, input logic [7:0] mk,
                              input int sv[8]);
    for (int p = 0; p < 8; p++) begin
      if (sv[p] != 0) return -1;
      if (rq[p] && !mk[p]) return p;
    end
    return -1;
  endfunction

  function automatic logic [7:0] up_view();
    logic [7:0] r;
    r = up_req;
    r[2] = (m_casc != 0);
    return r;
  endfunction

  function automatic logic [7:0] pack(input int sv[8]);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) r[p] = (sv[p] != 0);
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 8; p++) begin m_isr[p] = 0; s_isr[p] = 0; end
      m_casc = 0; m_vld = 0; m_vec = 0;
    end else begin
      int mw, sw;
      int nm[8], ns[8];
      mw = pick(up_view(), up_mask, m_isr);
      sw = pick(lo_req, lo_mask, s_isr);
      nm = m_isr; ns = s_isr;
      if (up_eoi) begin
        for (int p = 0; p < 8; p++) if (m_isr[p] != 0) begin nm[p] = 0; break; end
      end
      if (lo_eoi) begin
        for (int p = 0; p < 8; p++) if (s_isr[p] != 0) begin ns[p] = 0; break; end
      end
      if (ack) begin
        if (mw < 0) m_vec = (up_base & 8'hF8) + 7;
        else begin
          nm[mw] = 1;
          if (mw != 2) m_vec = (up_base & 8'hF8) + mw;
          else if (sw >= 0) begin ns[sw] = 1; m_vec = (lo_base & 8'hF8) + sw; end
          else m_vec = (lo_base & 8'hF8) + 7;
        end
      end
      m_vld  = ack;
      m_casc = (sw >= 0);
      m_isr = nm; s_isr = ns;
    end
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("model sys_irq", sys_irq, pick(up_view(), up_mask, m_isr) >= 0);
      chk("model vec_valid", vec_valid, m_vld);
      chk("model vector", vector, m_vec);
      chk("model up_isr", up_isr, pack(m_isr));
      chk("model lo_isr", lo_isr, pack(s_isr));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #3;
  endtask

  task automatic eoi_both();
    @(negedge clk); up_eoi = 1'b1; lo_eoi = 1'b1;
    @(negedge clk); up_eoi = 1'b0; lo_eoi = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1); #3;
    chk("R7 reset valid", vec_valid, 0);
    chk("R7 reset vector", vector, 0);
    chk("R1 reset irq", sys_irq, 0);

    // R2 / R6: upper line 5, base 0x25 -> 0x25
    @(negedge clk); up_req[5] = 1'b1; #3;
    chk("R1 irq follows upper", sys_irq, 1);
    do_ack();
    chk("R7 valid after ack", vec_valid, 1);
    chk("R2 R6 vector line5", vector, 8'h25);
    chk("R2 isr line5", up_isr, 8'h20);
    chk("R8 same line blocked", sys_irq, 0);
    @(negedge clk); #3;
    chk("R7 valid one cycle", vec_valid, 0);
    chk("R7 vector held", vector, 8'h25);

    // R8: higher line preempts
    @(negedge clk); up_req[0] = 1'b1; up_req[6] = 1'b1; #3;
    chk("R8 higher line raises", sys_irq, 1);
    do_ack();
    chk("R2 vector line0", vector, 8'h20);
    chk("R2 isr lines0,5", up_isr, 8'h21);

    // R9: non-specific eoi retires line 0, then 5
    @(negedge clk); up_eoi = 1'b1;
    @(negedge clk); up_eoi = 1'b0; #3;
    chk("R9 eoi clears line0", up_isr, 8'h20);
    up_req = '0;
    @(negedge clk); up_eoi = 1'b1;
    @(negedge clk); up_eoi = 1'b0; #3;
    chk("R9 eoi clears line5", up_isr, 8'h00);
    @(negedge clk); up_eoi = 1'b1;
    @(negedge clk); up_eoi = 1'b0; #3;
    chk("R9 eoi on empty", up_isr, 8'h00);

    // R10 masking, R1 upper bit 2 ignored
    @(negedge clk); up_mask[3] = 1'b1; up_req[3] = 1'b1; #3;
    chk("R10 masked line", sys_irq, 0);
    @(negedge clk); up_req[2] = 1'b1; cyc(2); #3;
    chk("R1 upper bit2 ignored", sys_irq, 0);
    @(negedge clk); up_req = '0; up_mask = '0;

    // R3: lower line 3 through cascade
    @(negedge clk); lo_req[3] = 1'b1; #3;
    chk("R1 cascade one cycle late", sys_irq, 0);
    @(negedge clk); #3;
    chk("R1 cascade raises", sys_irq, 1);
    do_ack();
    chk("R3 vector lower line3", vector, 8'h73);
    chk("R3 upper isr bit2", up_isr, 8'h04);
    chk("R3 lower isr bit3", lo_isr, 8'h08);
    lo_req = '0;
    eoi_both();

    // R4: lower request drops while the cascade register still holds it
    @(negedge clk); lo_req[4] = 1'b1;
    @(negedge clk); lo_req[4] = 1'b0; ack = 1'b1;
    @(negedge clk); ack = 1'b0; #3;
    chk("R4 lower spurious vector", vector, 8'h77);
    chk("R4 upper isr bit2", up_isr, 8'h04);
    chk("R4 lower isr unchanged", lo_isr, 8'h00);
    eoi_both();

    // R5: nothing pending
    cyc(2);
    do_ack();
    chk("R5 upper spurious vector", vector, 8'h27);
    chk("R5 isr unchanged", up_isr, 8'h00);

    // R6: different low base bits, same vector
    @(negedge clk); up_base = 8'h27; up_req[1] = 1'b1;
    do_ack();
    chk("R6 base low bits ignored", vector, 8'h21);
    up_req = '0;
    eoi_both();

    // randomized traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) up_req  = 8'($urandom);
      if ($urandom_range(0, 7) == 0) lo_req  = 8'($urandom);
      if ($urandom_range(0, 31) == 0) up_mask = 8'($urandom) & 8'h11;
      if ($urandom_range(0, 31) == 0) lo_mask = 8'($urandom) & 8'h22;
      if ($urandom_range(0, 63) == 0) begin
        up_base = 8'($urandom); lo_base = 8'($urandom);
      end
      ack    = ($urandom_range(0, 5) == 0);
      up_eoi = ($urandom_range(0, 4) == 0);
      lo_eoi = ($urandom_range(0, 4) == 0);
    end
    @(negedge clk); ack = 0; up_eoi = 0; lo_eoi = 0;
    cyc(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule